// File: doc/BRIEF.md
# DC Level Measurement Accumulator

This block turns a stream of signed 19-bit DC measurement samples into one integrated level figure. The samples arrive at about 2 kHz and are already decimated. Each accepted sample goes through four steps: a programmable 16-bit offset is subtracted, an optional gain of 16 is applied, an optional rectifier takes the absolute value, and a programmable right shift scales it. The scaled terms are then summed over a programmable number of samples. When the run ends, a one-cycle done pulse is raised and a 24-bit signed result is presented. If the sum does not fit in 24 bits, the result is clamped to positive or negative full scale.

Software sets up the block through a small byte-wide write port. A start pulse then begins an integration run. Sample intake uses a valid/ready pair. The block never applies back-pressure: ready is held high at all times. A sample counts only if valid is high on a clock edge while a run is in progress and start is low. The done pulse and result are plain status outputs with no handshake. The result stays unchanged until the next done pulse.

Top module: `dclvl_acc`

## Requirements
- R1: After reset, done is 0, result is 0 and no run is in progress.
- R2: The offset is written at byte address 0 (low byte) and address 1 (high byte). It is a 16-bit two's-complement value and is subtracted from every sample. The difference saturates to the 19-bit signed range [-262144, 262143].
- R3: Bit 0 of the control byte at address 2 selects the gain: 0 gives gain 1 and 1 gives gain 16. The product saturates to the 19-bit signed range.
- R4: Bit 1 of the control byte enables the rectifier, which replaces a negative value with its magnitude. The value -262144 maps to 262143. When the bit is 0, the signed value passes through unchanged.
- R5: Bits 4:2 of the control byte hold the shift amount K (0 to 7). Each term is the rectified value arithmetically shifted right by K, so that negative values round toward minus infinity.
- R6: The run length N is a 16-bit count, written at address 3 (low byte) and address 4 (high byte), and sampled when start is asserted. N = 0 is treated as 1. The done pulse appears one cycle after the edge that accepts the N-th sample, and result then equals the sum of the N terms.
- R7: A sum above 8388607 gives a result of 8388607 (0x7FFFFF). A sum below -8388608 gives a result of -8388608 (0x800000).
- R8: Valid samples that arrive when no run is in progress do not change the result and do not raise done.
- R9: Asserting start during a run discards the partial sum and begins a new run. No done pulse appears in the cycle after start, and a sample presented in the same cycle as start is not counted.
- R10: done is high for exactly one cycle per run, and result changes only together with done.
- R11: in_ready is 1 in every cycle after reset, so no sample is ever back-pressured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| start | input | 1 | Begin (or restart) an integration run |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample ready, always high |
| in_sample | input | 19 | Signed decimated sample |
| done | output | 1 | One-cycle pulse when a run completes |
| result | output | 24 | Signed saturated level result |

## Verification
The assertions assume three things about the inputs: reset is low long enough to clear the state, start is a single-cycle pulse, and configuration writes other than the run length do not happen while a run is in progress. The offset, gain, rectifier and shift settings act on each sample as it arrives, so changing them mid-run would make the expected sum ambiguous. The bench therefore writes every register before the start pulse and changes inputs only on falling edges. It also keeps in_valid low between runs, except in the test that deliberately offers idle samples to check that they are ignored.

// File: rtl/dclvl_pkg.sv
package dclvl_pkg;
  localparam int OFF_W   = 16;
  localparam int SHIFT_W = 3;
  localparam int LEN_W   = 16;
  localparam int ADDR_W  = 3;
  localparam int BYTE_W  = 8;

  localparam logic [ADDR_W-1:0] A_OFF_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_OFF_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_LEN_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_LEN_HI = 3'd4;

  typedef struct packed {
    logic [OFF_W-1:0]   offset;
    logic               gain16;
    logic               rectify;
    logic [SHIFT_W-1:0] shift;
    logic [LEN_W-1:0]   length;
  } cfg_t;
endpackage

// File: rtl/dclvl_regs.sv
module dclvl_regs
  import dclvl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output cfg_t              cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      unique case (addr)
        A_OFF_LO: cfg.offset[BYTE_W-1:0]       <= wdata;
        A_OFF_HI: cfg.offset[OFF_W-1:BYTE_W]   <= wdata;
        A_CTRL: begin
          cfg.gain16  <= wdata[0];
          cfg.rectify <= wdata[1];
          cfg.shift   <= wdata[2 +: SHIFT_W];
        end
        A_LEN_LO: cfg.length[BYTE_W-1:0]       <= wdata;
        A_LEN_HI: cfg.length[LEN_W-1:BYTE_W]   <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dclvl_cond.sv
module dclvl_cond
  import dclvl_pkg::*;
#(
  parameter int SAMPLE_W = 19
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  cfg_t                       cfg,
  output logic signed [SAMPLE_W-1:0] term
);
  localparam int DW = SAMPLE_W + 2;
  localparam int GW = DW + 4;
  localparam logic signed [GW-1:0] SMAX = GW'((2 ** (SAMPLE_W - 1)) - 1);
  localparam logic signed [GW-1:0] SMIN = -GW'(2 ** (SAMPLE_W - 1));

  logic signed [GW-1:0] diff_w, diff_s, gain_w, gain_s, rect_v, shr_v;

  always_comb begin
    // offset subtraction with saturation
    diff_w = GW'(sample) - GW'($signed(cfg.offset));
    if (diff_w > SMAX)      diff_s = SMAX;
    else if (diff_w < SMIN) diff_s = SMIN;
    else                    diff_s = diff_w;
    // optional x16 gain with saturation
    gain_w = cfg.gain16 ? (diff_s <<< 4) : diff_s;
    if (gain_w > SMAX)      gain_s = SMAX;
    else if (gain_w < SMIN) gain_s = SMIN;
    else                    gain_s = gain_w;
    // optional rectifier
    if (cfg.rectify && gain_s < 0) rect_v = (gain_s == SMIN) ? SMAX : -gain_s;
    else                           rect_v = gain_s;
    // scaling shift
    shr_v = rect_v >>> cfg.shift;
    term  = shr_v[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/dclvl_integ.sv
module dclvl_integ
  import dclvl_pkg::*;
#(
  parameter int SAMPLE_W = 19,
  parameter int RES_W    = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       take,
  input  logic signed [SAMPLE_W-1:0] term,
  input  logic [LEN_W-1:0]           length,
  output logic                       done,
  output logic signed [RES_W-1:0]    result
);
  localparam int ACC_W = SAMPLE_W + LEN_W + 1;
  localparam logic signed [ACC_W-1:0] RMAX = ACC_W'((2 ** (RES_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] RMIN = -ACC_W'(2 ** (RES_W - 1));

  logic                    running;
  logic [LEN_W-1:0]        cnt, len_q;
  logic signed [ACC_W-1:0] acc, sum;
  logic signed [RES_W-1:0] clamped;

  always_comb begin
    sum = acc + ACC_W'(term);
    if (sum > RMAX)      clamped = RMAX[RES_W-1:0];
    else if (sum < RMIN) clamped = RMIN[RES_W-1:0];
    else                 clamped = sum[RES_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      len_q   <= '0;
      acc     <= '0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        running <= 1'b1;
        cnt     <= '0;
        acc     <= '0;
        len_q   <= (length == '0) ? LEN_W'(1) : length;
      end else if (running && take) begin
        if (cnt == len_q - LEN_W'(1)) begin
          running <= 1'b0;
          done    <= 1'b1;
          result  <= clamped;
        end else begin
          acc <= sum;
          cnt <= cnt + LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dclvl_acc.sv
module dclvl_acc
  import dclvl_pkg::*;
#(
  parameter int SAMPLE_W = 19,
  parameter int RES_W    = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [BYTE_W-1:0]          cfg_wdata,
  input  logic                       start,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic                       done,
  output logic signed [RES_W-1:0]    result
);
  cfg_t                       cfg;
  logic signed [SAMPLE_W-1:0] term;

  assign in_ready = 1'b1;

  dclvl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .cfg(cfg)
  );

  dclvl_cond #(.SAMPLE_W(SAMPLE_W)) u_cond (
    .sample(in_sample), .cfg(cfg), .term(term)
  );

  dclvl_integ #(.SAMPLE_W(SAMPLE_W), .RES_W(RES_W)) u_integ (
    .clk(clk), .rst_n(rst_n), .start(start), .take(in_valid && in_ready),
    .term(term), .length(cfg.length), .done(done), .result(result)
  );
endmodule

// File: rtl/dclvl_acc_chk.sv
module dclvl_acc_chk #(
  parameter int RES_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             in_valid,
  input logic             done,
  input logic [RES_W-1:0] result
);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  assert_restart_no_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  assert_done_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(in_valid) && !$past(start));
endmodule

bind dclvl_acc dclvl_acc_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
  .done(done), .result(result)
);

// File: tb/dclvl_acc_tb.sv
module dclvl_acc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic signed [18:0] in_sample = '0;
  logic        done;
  logic signed [23:0] result;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dclvl_acc u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_sample(in_sample), .done(done), .result(result)
  );

  // offset, gain, rect, K, N, sample, expected
  localparam int VEC [12][7] = '{
    '{0,     0, 0, 0, 4,  100,     400},
    '{10,    0, 0, 0, 3,  5,       -15},
    '{0,     1, 0, 0, 2,  -3,      -96},
    '{0,     0, 1, 0, 5,  -7,      35},
    '{0,     0, 0, 3, 8,  -20,     -24},
    '{0,     1, 0, 0, 2,  20000,   524286},
    '{32768, 0, 0, 0, 1,  262143,  262143},
    '{0,     0, 0, 0, 40, 262143,  8388607},
    '{0,     0, 0, 0, 40, -262144, -8388608},
    '{0,     0, 1, 0, 1,  -262144, 262143},
    '{0,     0, 0, 7, 1,  255,     1},
    '{0,     0, 0, 0, 0,  9,       9}
  };
  localparam string VREQ [12] = '{"R6", "R2", "R3", "R4", "R5", "R3",
                                  "R2", "R7", "R7", "R4", "R5", "R6"};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int off, input int g, input int r, input int k, input int n);
    wr(3'd0, off[7:0]);
    wr(3'd1, off[15:8]);
    wr(3'd2, {3'b000, k[2:0], r[0], g[0]});
    wr(3'd3, n[7:0]);
    wr(3'd4, n[15:8]);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic feed(input int s, input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_sample = s[18:0];
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic signed [23:0] held;
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready", in_ready, 1);

    for (int v = 0; v < 12; v++) begin
      setup(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
      pulse_start();
      feed(VEC[v][5], (VEC[v][4] == 0) ? 1 : VEC[v][4]);
      chk({VREQ[v], " done"}, done, 1);
      chk({VREQ[v], " result"}, result, VEC[v][6]);
      @(negedge clk);
      chk("R10 pulse", done, 0);
    end

    // R8: samples while idle are ignored
    held = result;
    feed(1000, 5);
    chk("R8 done", done, 0);
    chk("R8 result", result, held);
    chk("R11 ready", in_ready, 1);

    // R9: restart aborts partial run; sample with start not counted
    setup(0, 0, 0, 0, 4);
    pulse_start();
    feed(50, 3);
    start = 1'b1; in_valid = 1'b1; in_sample = 19'sd500;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    chk("R9 no done", done, 0);
    feed(1, 4);
    chk("R9 done", done, 1);
    chk("R9 result", result, 4);

    // R10: result held over idle cycles
    held = result;
    repeat (5) @(negedge clk);
    chk("R10 held", result, held);
    chk("R10 done low", done, 0);

    // R6: gaps in valid do not break the count
    setup(0, 0, 0, 0, 3);
    pulse_start();
    feed(7, 1);
    @(negedge clk);
    feed(7, 1);
    chk("R6 not early", done, 0);
    @(negedge clk);
    feed(7, 1);
    chk("R6 gap done", done, 1);
    chk("R6 gap result", result, 21);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule